// File: doc/BRIEF.md
# Bidirectional Row Scan Shifter

This block drives the row (common) electrodes of a dot-matrix panel. A scan token is clocked along a chain of one-bit stages, one step for every falling edge of a line pulse. Each stage's bit and the frame polarity input decide a two-bit drive-level code for that row, which a separate analog stage turns into a voltage. Several of these blocks can be chained: the token enters on one of two bidirectional cascade pins and leaves on the other.

Two static inputs pick one of four shift layouts. The register can run as one long chain or be split into two equal halves, and data can move toward higher or toward lower row numbers. In the split layout, a dedicated input feeds the second half, so two panel regions can be scanned at once. The direction input also decides which cascade pin is the input and which drives. A blanking input, active low, clears the chain, stops it and forces every row to the lowest rail. The pad circuitry is outside this block. Each cascade pin is modelled as a separate input, output and output enable.

The block works on the system clock. The line pulse is sampled there, and a high-to-low change seen at a clock edge counts as one shift. All pins are plain levels. No transfer at the edge of the block needs a valid/ready handshake, so none is provided.

Top module: `rowscan_shifter`

## Requirements
- R1: After reset every stage holds 0 and both cascade outputs are 0. With polarity 0 every row code is 2'b01.
- R2: The stages change only at a clock edge where the sampled line pulse goes from 1 to 0. Each such edge shifts by exactly one place. A line pulse that stays high, or goes from 0 to 1, leaves the stages unchanged.
- R3: Long chain with dir_fwd=1. Stage 0 takes eio_a_in and stage i takes stage i-1. eio_b_out shows stage STAGES-1, so a token entered on the first shift shows there after STAGES shifts.
- R4: Long chain with dir_fwd=0. Stage STAGES-1 takes eio_b_in and stage i takes stage i+1. eio_a_out shows stage 0.
- R5: Split chain with dir_fwd=1. Stage 0 takes eio_a_in and stage HALF takes half_in. Each half shifts upward on its own. eio_b_out shows stage HALF-1.
- R6: Split chain with dir_fwd=0. Stage STAGES-1 takes eio_b_in and stage HALF-1 takes half_in. Each half shifts downward on its own. eio_a_out shows stage HALF.
- R7: With dir_fwd=1, eio_b_oe=1, eio_a_oe=0 and eio_a_out=0. With dir_fwd=0, eio_a_oe=1, eio_b_oe=0 and eio_b_out=0.
- R8: In the long chain, half_in has no effect on any stage.
- R9: When blank_n=1, the row code for stage bit b and polarity f is {f, ~(b^f)}. The codes are 2'b00 lowest rail, 2'b01 second, 2'b10 third and 2'b11 highest. So b=1,f=0 gives 00, b=0,f=0 gives 01, b=0,f=1 gives 10 and b=1,f=1 gives 11.
- R10: While blank_n=0, every row code is 2'b00 at once. At each clock edge the stages are cleared, and line-pulse edges do not shift them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lp | input | 1 | Line pulse; a falling edge shifts the chain |
| dual | input | 1 | 0: one chain of STAGES; 1: two chains of HALF |
| dir_fwd | input | 1 | 1: shift toward higher stage index; 0: toward lower |
| blank_n | input | 1 | Active-low blanking: clear, hold, lowest rail |
| frame_inv | input | 1 | Frame polarity for the level code |
| eio_a_in | input | 1 | Cascade pin A, input side |
| eio_a_out | output | 1 | Cascade pin A, output side |
| eio_a_oe | output | 1 | Cascade pin A drive enable |
| eio_b_in | input | 1 | Cascade pin B, input side |
| eio_b_out | output | 1 | Cascade pin B, output side |
| eio_b_oe | output | 1 | Cascade pin B drive enable |
| half_in | input | 1 | Second-chain data input in split mode |
| lvl | output | 2*STAGES | Row codes; bits [2i+1:2i] belong to stage i |

## Verification
The line pulse drops before clock edge N. The shift happens at edge N, so the new stage contents, and the cascade output taken from them, can be read from the half cycle after edge N. The row codes follow frame_inv and blank_n in the same cycle, because no register lies between them. The bench drives every input on the falling clock edge and compares after the next falling edge, one rising edge after the line pulse dropped. Blanking is checked twice: the codes a moment after blank_n falls, and the cleared stages after the following rising edge.

// File: rtl/rowscan_pkg.sv
package rowscan_pkg;

  typedef enum logic [1:0] {
    LVL_RAIL0 = 2'b00,
    LVL_RAIL1 = 2'b01,
    LVL_RAIL2 = 2'b10,
    LVL_RAIL3 = 2'b11
  } drive_lvl_e;

  // Row code from stage bit and frame polarity; blanking forces lowest rail.
  function automatic drive_lvl_e row_code(input logic bit_v, input logic pol,
                                          input logic on);
    if (!on) return LVL_RAIL0;
    return drive_lvl_e'({pol, ~(bit_v ^ pol)});
  endfunction

endpackage

// File: rtl/rowscan_strobe.sv
module rowscan_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic lp,
  output logic shift_en
);

  logic lp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lp_q <= 1'b0;
    else        lp_q <= lp;
  end

  assign shift_en = lp_q & ~lp;

  // A falling edge yields a single-cycle strobe (R2)
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> !shift_en);

endmodule

// File: rtl/rowscan_chain.sv
module rowscan_chain #(
  parameter int STAGES = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              blank_n,
  input  logic              dual,
  input  logic              dir_fwd,
  input  logic              in_a,
  input  logic              in_b,
  input  logic              in_mid,
  output logic [STAGES-1:0] stages
);

  localparam int HALF = STAGES / 2;

  logic [STAGES-1:0] nxt;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic up_src;
    logic dn_src;
    if (i == 0) begin : g_up_head
      assign up_src = in_a;
    end else if (i == HALF) begin : g_up_mid
      assign up_src = dual ? in_mid : stages[i-1];
    end else begin : g_up_body
      assign up_src = stages[i-1];
    end
    if (i == STAGES - 1) begin : g_dn_head
      assign dn_src = in_b;
    end else if (i == HALF - 1) begin : g_dn_mid
      assign dn_src = dual ? in_mid : stages[i+1];
    end else begin : g_dn_body
      assign dn_src = stages[i+1];
    end
    assign nxt[i] = dir_fwd ? up_src : dn_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stages <= '0;
    else if (!blank_n) stages <= '0;
    else if (shift_en) stages <= nxt;
  end

  assert_blank_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> (stages == '0));

  assert_hold_without_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && !shift_en) |=> $stable(stages));

  assert_long_up_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && blank_n && !dual && dir_fwd) |=> (stages[0] == $past(in_a)));

  assert_split_down_mid_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && blank_n && dual && !dir_fwd) |=> (stages[HALF-1] == $past(in_mid)));

endmodule

// File: rtl/rowscan_levels.sv
module rowscan_levels #(
  parameter int STAGES = 160
) (
  input  logic [STAGES-1:0]   stages,
  input  logic                pol,
  input  logic                blank_n,
  output logic [2*STAGES-1:0] lvl
);

  import rowscan_pkg::*;

  for (genvar i = 0; i < STAGES; i++) begin : g_code
    assign lvl[2*i +: 2] = row_code(stages[i], pol, blank_n);
  end

endmodule

// File: rtl/rowscan_shifter.sv
module rowscan_shifter #(
  parameter int STAGES = 160
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lp,
  input  logic                dual,
  input  logic                dir_fwd,
  input  logic                blank_n,
  input  logic                frame_inv,
  input  logic                eio_a_in,
  output logic                eio_a_out,
  output logic                eio_a_oe,
  input  logic                eio_b_in,
  output logic                eio_b_out,
  output logic                eio_b_oe,
  input  logic                half_in,
  output logic [2*STAGES-1:0] lvl
);

  localparam int HALF = STAGES / 2;

  logic              shift_en;
  logic [STAGES-1:0] stages;
  logic              tail_up;
  logic              tail_dn;

  rowscan_strobe u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .lp       (lp),
    .shift_en (shift_en)
  );

  rowscan_chain #(.STAGES(STAGES)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .blank_n  (blank_n),
    .dual     (dual),
    .dir_fwd  (dir_fwd),
    .in_a     (eio_a_in),
    .in_b     (eio_b_in),
    .in_mid   (half_in),
    .stages   (stages)
  );

  rowscan_levels #(.STAGES(STAGES)) u_levels (
    .stages  (stages),
    .pol     (frame_inv),
    .blank_n (blank_n),
    .lvl     (lvl)
  );

  // Cascade output is the tail of the chain fed by the cascade input
  assign tail_up   = dual ? stages[HALF-1] : stages[STAGES-1];
  assign tail_dn   = dual ? stages[HALF]   : stages[0];
  assign eio_b_oe  = dir_fwd;
  assign eio_a_oe  = ~dir_fwd;
  assign eio_b_out = dir_fwd & tail_up;
  assign eio_a_out = ~dir_fwd & tail_dn;

  assert_pin_roles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({eio_a_oe, eio_b_oe}) && !(eio_a_out && !eio_a_oe) && !(eio_b_out && !eio_b_oe));

endmodule

// File: tb/rowscan_shifter_tb_top.sv
module rowscan_shifter_tb_top;

  localparam int S = 160;
  localparam int H = S / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp = 1'b0, dual = 1'b0, dir_fwd = 1'b1, blank_n = 1'b1, frame_inv = 1'b0;
  logic eio_a_in = 1'b0, eio_b_in = 1'b0, half_in = 1'b0;
  logic eio_a_out, eio_a_oe, eio_b_out, eio_b_oe;
  logic [2*S-1:0] lvl;

  int checks = 0;
  int fails = 0;
  logic [S-1:0] exp_bits;

  always #5 clk = ~clk;

  rowscan_shifter #(.STAGES(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .lp(lp), .dual(dual), .dir_fwd(dir_fwd),
    .blank_n(blank_n), .frame_inv(frame_inv),
    .eio_a_in(eio_a_in), .eio_a_out(eio_a_out), .eio_a_oe(eio_a_oe),
    .eio_b_in(eio_b_in), .eio_b_out(eio_b_out), .eio_b_oe(eio_b_oe),
    .half_in(half_in), .lvl(lvl)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input logic [2*S-1:0] act, input logic [2*S-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [S-1:0] seen_bits();
    logic [S-1:0] b;
    for (int i = 0; i < S; i++) b[i] = ~lvl[2*i] ^ frame_inv;
    return b;
  endfunction

  task automatic compare(input string req);
    logic [S-1:0] got;
    logic ea, eb;
    got = seen_bits();
    check(got == exp_bits, req, "stages", {{S{1'b0}}, got}, {{S{1'b0}}, exp_bits});
    eb = dir_fwd ? (dual ? exp_bits[H-1] : exp_bits[S-1]) : 1'b0;
    ea = dir_fwd ? 1'b0 : (dual ? exp_bits[H] : exp_bits[0]);
    check(eio_a_out == ea && eio_b_out == eb, req, "cascade out",
          {{(2*S-2){1'b0}}, eio_a_out, eio_b_out}, {{(2*S-2){1'b0}}, ea, eb});
  endtask

  // One line-pulse fall with inputs held; the model follows R3-R6 and R8
  task automatic step(input logic a, input logic b, input logic d7);
    logic [S-1:0] o;
    @(negedge clk);
    eio_a_in = a; eio_b_in = b; half_in = d7; lp = 1'b1;
    @(negedge clk);
    lp = 1'b0;
    @(negedge clk);
    o = exp_bits;
    for (int i = 0; i < S; i++) begin
      if (dir_fwd)
        exp_bits[i] = (i == 0) ? a : ((i == H && dual) ? d7 : o[i-1]);
      else
        exp_bits[i] = (i == S-1) ? b : ((i == H-1 && dual) ? d7 : o[i+1]);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); blank_n = 1'b0;
    @(negedge clk); blank_n = 1'b1;
    exp_bits = '0;
  endtask

  task automatic t_reset();
    check(lvl == {S{2'b01}}, "R1", "codes after reset", lvl, {S{2'b01}});
    check(!eio_a_out && !eio_b_out, "R1", "cascade outs after reset",
          {{(2*S-2){1'b0}}, eio_a_out, eio_b_out}, '0);
  endtask

  task automatic t_single_up();
    dual = 1'b0; dir_fwd = 1'b1; clear_all();
    check(eio_b_oe && !eio_a_oe, "R7", "enables up", {eio_a_oe, eio_b_oe}, 2'b01);
    step(1'b1, 1'b0, 1'b1); compare("R3");
    for (int k = 2; k <= S; k++) begin
      step(1'b0, 1'b0, 1'b1);
      if (k == H || k == H + 1) compare("R8");
    end
    compare("R3");
    check(eio_b_out == 1'b1, "R3", "token at tail", eio_b_out, 1'b1);
    step(1'b0, 1'b0, 1'b0); compare("R3");
  endtask

  task automatic t_hold();
    dual = 1'b0; dir_fwd = 1'b1; clear_all();
    step(1'b1, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0);
    @(negedge clk); lp = 1'b1;
    repeat (5) @(negedge clk);
    compare("R2");
    lp = 1'b0; @(negedge clk); lp = 1'b0;
    exp_bits = {exp_bits[S-2:0], 1'b1};
    compare("R2");
  endtask

  task automatic t_single_down();
    dual = 1'b0; dir_fwd = 1'b0; clear_all();
    check(eio_a_oe && !eio_b_oe, "R7", "enables down", {eio_a_oe, eio_b_oe}, 2'b10);
    step(1'b0, 1'b1, 1'b1);
    for (int k = 2; k <= S; k++) begin
      step(1'b0, 1'b0, 1'b1);
      if (k == H) compare("R8");
    end
    compare("R4");
    check(eio_a_out == 1'b1, "R4", "token at tail", eio_a_out, 1'b1);
  endtask

  task automatic t_dual_up();
    dual = 1'b1; dir_fwd = 1'b1; clear_all();
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1); compare("R5");
    check(seen_bits() == ((S'(1) << 1) | (S'(1) << H)), "R5", "mid entry",
          {{S{1'b0}}, seen_bits()}, {{S{1'b0}}, (S'(1) << 1) | (S'(1) << H)});
    for (int k = 3; k <= H; k++) step(1'b0, 1'b0, 1'b0);
    compare("R5");
    check(eio_b_out == 1'b1, "R5", "first chain tail", eio_b_out, 1'b1);
  endtask

  task automatic t_dual_down();
    dual = 1'b1; dir_fwd = 1'b0; clear_all();
    step(1'b0, 1'b1, 1'b1); compare("R6");
    check(seen_bits() == ((S'(1) << (S-1)) | (S'(1) << (H-1))), "R6", "mid entry",
          {{S{1'b0}}, seen_bits()}, {{S{1'b0}}, (S'(1) << (S-1)) | (S'(1) << (H-1))});
    for (int k = 2; k <= H; k++) step(1'b0, 1'b0, 1'b0);
    compare("R6");
    check(eio_a_out == 1'b1, "R6", "first chain tail", eio_a_out, 1'b1);
  endtask

  task automatic t_levels();
    dual = 1'b0; dir_fwd = 1'b1; clear_all();
    step(1'b1, 1'b0, 1'b0);
    frame_inv = 1'b0; #1;
    check(lvl[3:0] == 4'b0100, "R9", "codes pol0", lvl[3:0], 4'b0100);
    frame_inv = 1'b1; #1;
    check(lvl[3:0] == 4'b1011, "R9", "codes pol1", lvl[3:0], 4'b1011);
    frame_inv = 1'b0;
  endtask

  task automatic t_blank();
    dual = 1'b0; dir_fwd = 1'b1; clear_all();
    step(1'b1, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0);
    @(negedge clk); blank_n = 1'b0; #1;
    check(lvl == '0, "R10", "codes while blank", lvl, '0);
    eio_a_in = 1'b1; lp = 1'b1;
    @(negedge clk); lp = 1'b0;
    @(negedge clk);
    check(lvl == '0, "R10", "codes blank after pulse", lvl, '0);
    blank_n = 1'b1; #1;
    exp_bits = '0;
    compare("R10");
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    exp_bits = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_up();
    t_hold();
    t_single_down();
    t_dual_up();
    t_dual_down();
    t_levels();
    t_blank();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule